// File: doc/BRIEF.md
# Per-Pixel Palette / Truecolour Mixer

This block turns the pixels of one scanline of a dual-plane framebuffer into 32-bit output pixels. For every pixel position it takes three values at once: an 8-bit colour index from the indexed plane, a 32-bit truecolour word and a 32-bit control word. A tag in the control word decides, pixel by pixel, whether the pixel is shown from the 256-entry colour table or from the truecolour word. All input words arrive big-endian: memory byte 0 sits in bits 31:24.

The truecolour word keeps its bytes blue first: memory byte 1 is blue, byte 2 is green, byte 3 is red, and byte 0 is ignored. The block repacks these bytes as RGB or BGR under a select input. Colour table entries are expected to be stored already in the packing the display uses, so they pass through unchanged. The block reads the table through a synchronous read port, one read per accepted pixel. Results leave on a valid/ready stream at one pixel per clock, with a flag on the last visible pixel of each line. The visible width is a parameter of at most 1024, the fixed line stride of every plane.

Top module: `mixpix_top`

## Requirements
- R1: A pixel takes the truecolour path exactly when `in_ctrl[31:24]` equals 8'h03.
- R2: Every other tag value, including 8'h02, 8'h13 and 8'h83, selects the colour table path.
- R3: On the truecolour path blue is `in_direct[23:16]`, green is `in_direct[15:8]`, red is `in_direct[7:0]`, and `in_direct[31:24]` has no effect.
- R4: A truecolour result is `{8'h00, R, G, B}` when `bgr_sel` is 0 and `{8'h00, B, G, R}` when `bgr_sel` is 1.
- R5: A colour table result equals the 32-bit table word for `in_index` unchanged, whatever `bgr_sel` is.
- R6: `bgr_sel` is taken with each pixel at the cycle it is accepted, so changing it affects only pixels accepted afterwards.
- R7: With `out_ready` held high the block accepts one pixel per clock, a pixel appears on the output two clocks after acceptance, and output order equals input order.
- R8: While `out_valid` is high and `out_ready` is low, `out_pixel` and `out_last` stay stable and `in_ready` is low, so all three input streams stall together.
- R9: `out_last` is high on every `LINE_W`-th pixel accepted since reset and low on all others.
- R10: After reset `out_valid` is low, `in_ready` is high, and the first accepted pixel is column 0 of a line.
- R11: `pal_rd_en` is high in the cycle a pixel is accepted, with `pal_rd_addr` equal to `in_index`; table data is taken one clock later and the table holds its read data while `pal_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bgr_sel | input | 1 | Truecolour packing: 0 RGB, 1 BGR |
| in_valid | input | 1 | Input pixel triple valid |
| in_ready | output | 1 | Block accepts the input triple |
| in_index | input | 8 | Colour index from the indexed plane |
| in_direct | input | 32 | Truecolour word, big-endian, blue first |
| in_ctrl | input | 32 | Control word, tag in bits 31:24 |
| pal_rd_en | output | 1 | Colour table read enable |
| pal_rd_addr | output | 8 | Colour table read address |
| pal_rd_data | input | 32 | Colour table read data, one clock after enable |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts output pixel |
| out_pixel | output | 32 | Output pixel |
| out_last | output | 1 | Last visible pixel of a line |

## Verification
The bench sweeps control tags whose low bits or top bits resemble the truecolour tag (8'h13, 8'h83, 8'h02); a decoder that tests only part of the tag byte would show table colours as truecolour or the reverse. It toggles `bgr_sel` from one pixel to the next, which catches a design that samples the select at the output or lets it repack table entries, and it fills byte 0 of truecolour words with noise to expose a design that leaks it into the top byte. Random backpressure checks that a stalled pixel does not change and that the table read is not lost or repeated. A short line width tests that the end-of-line flag falls on the right pixel and wraps.

// File: rtl/mixpix_pkg.sv
package mixpix_pkg;

  localparam int unsigned PIX_W      = 32;
  localparam int unsigned IDX_W      = 8;
  localparam int unsigned LINE_STRIDE = 1024;
  localparam logic [7:0]  TAG_DIRECT = 8'h03;

  typedef struct packed {
    logic             use_direct;
    logic [PIX_W-1:0] direct_pix;
    logic             last;
  } mid_t;

  function automatic logic [PIX_W-1:0] pack_color(input logic [7:0] red,
                                                  input logic [7:0] grn,
                                                  input logic [7:0] blu,
                                                  input logic       bgr);
    pack_color = bgr ? {8'h00, blu, grn, red} : {8'h00, red, grn, blu};
  endfunction

endpackage

// File: rtl/mixpix_decode.sv
module mixpix_decode
  import mixpix_pkg::*;
(
  input  logic [PIX_W-1:0] ctrl_word,
  input  logic [PIX_W-1:0] direct_word,
  input  logic             bgr,
  output logic             use_direct,
  output logic [PIX_W-1:0] direct_pix
);

  logic [7:0] blu, grn, red;
  logic       unused_bits;

  // big-endian lanes: byte 0 in [31:24], then blue, green, red
  assign blu = direct_word[23:16];
  assign grn = direct_word[15:8];
  assign red = direct_word[7:0];

  assign use_direct  = (ctrl_word[31:24] == TAG_DIRECT);
  assign direct_pix  = pack_color(red, grn, blu, bgr);
  assign unused_bits = ^{direct_word[31:24], ctrl_word[23:0]};

endmodule

// File: rtl/mixpix_linepos.sv
module mixpix_linepos #(
  parameter int unsigned LINE_W = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic is_last
);

  localparam int unsigned CW = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam logic [CW-1:0] COL_MAX = CW'(LINE_W - 1);

  logic [CW-1:0] col_q, col_d;

  assign is_last = (col_q == COL_MAX);

  always_comb begin
    col_d = col_q;
    if (step) begin
      if (is_last) col_d = '0;
      else         col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end

  a_r9_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_MAX);

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_last) |=> (col_q == '0));

endmodule

// File: rtl/mixpix_outstage.sv
module mixpix_outstage
  import mixpix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             mid_valid,
  input  mid_t             mid,
  input  logic [PIX_W-1:0] pal_data,
  output logic             o_valid,
  output logic [PIX_W-1:0] o_pixel,
  output logic             o_last
);

  logic             v_d, l_d;
  logic [PIX_W-1:0] p_d;

  always_comb begin
    v_d = o_valid;
    p_d = o_pixel;
    l_d = o_last;
    if (adv) begin
      v_d = mid_valid;
      p_d = mid.use_direct ? mid.direct_pix : pal_data;
      l_d = mid.last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_pixel <= '0;
      o_last  <= 1'b0;
    end else begin
      o_valid <= v_d;
      o_pixel <= p_d;
      o_last  <= l_d;
    end
  end

endmodule

// File: rtl/mixpix_top.sv
module mixpix_top
  import mixpix_pkg::*;
#(
  parameter int unsigned LINE_W = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bgr_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  input  logic [PIX_W-1:0] in_direct,
  input  logic [PIX_W-1:0] in_ctrl,
  output logic             pal_rd_en,
  output logic [IDX_W-1:0] pal_rd_addr,
  input  logic [PIX_W-1:0] pal_rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel,
  output logic             out_last
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic adv, accept, use_direct_c, is_last_c;
  logic [PIX_W-1:0] direct_pix_c;

  assign adv         = !out_valid || out_ready;
  assign in_ready    = adv && rst_ok;
  assign accept      = in_valid && in_ready;
  assign pal_rd_en   = accept;
  assign pal_rd_addr = in_index;

  mixpix_decode u_decode (
    .ctrl_word   (in_ctrl),
    .direct_word (in_direct),
    .bgr         (bgr_sel),
    .use_direct  (use_direct_c),
    .direct_pix  (direct_pix_c)
  );

  mixpix_linepos #(.LINE_W(LINE_W)) u_linepos (
    .clk     (clk),
    .rst_n   (rst_ok),
    .step    (accept),
    .is_last (is_last_c)
  );

  // stage A: pixel waits here while its table word is read
  logic a_valid_q, a_valid_d;
  mid_t a_mid_q, a_mid_d;

  always_comb begin
    a_valid_d = a_valid_q;
    a_mid_d   = a_mid_q;
    if (adv) begin
      a_valid_d          = accept;
      a_mid_d.use_direct = use_direct_c;
      a_mid_d.direct_pix = direct_pix_c;
      a_mid_d.last       = is_last_c;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      a_valid_q <= 1'b0;
      a_mid_q   <= '0;
    end else begin
      a_valid_q <= a_valid_d;
      a_mid_q   <= a_mid_d;
    end
  end

  mixpix_outstage u_out (
    .clk       (clk),
    .rst_n     (rst_ok),
    .adv       (adv),
    .mid_valid (a_valid_q),
    .mid       (a_mid_q),
    .pal_data  (pal_rd_data),
    .o_valid   (out_valid),
    .o_pixel   (out_pixel),
    .o_last    (out_last)
  );

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pixel) && $stable(out_last)));

  a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && !out_ready) |-> !in_ready);

  a_r7_stage_fill: assert property (@(posedge clk) disable iff (!rst_ok)
    pal_rd_en |=> a_valid_q);

  a_r4_top_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_valid_q && a_mid_q.use_direct) |-> (a_mid_q.direct_pix[31:24] == 8'h00));

endmodule

// File: tb/tb_mixpix_top.sv
`timescale 1ns/100ps
module tb_mixpix_top;

  localparam int LW = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bgr_sel, in_valid, in_ready, out_ready;
  logic [7:0]  in_index;
  logic [31:0] in_direct, in_ctrl;
  logic        pal_rd_en;
  logic [7:0]  pal_rd_addr;
  logic [31:0] pal_rd_data;
  logic        out_valid, out_last;
  logic [31:0] out_pixel;

  always #2 clk = ~clk;

  mixpix_top #(.LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .bgr_sel(bgr_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
    .in_direct(in_direct), .in_ctrl(in_ctrl),
    .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel), .out_last(out_last)
  );

  // colour table model: synchronous read, holds data while not enabled (R11)
  logic [31:0] pal [256];
  initial for (int i = 0; i < 256; i++)
    pal[i] = {8'(i) ^ 8'h5A, 8'(i * 7), ~8'(i), 8'(i + 3)};
  always @(posedge clk) if (pal_rd_en) pal_rd_data <= pal[pal_rd_addr];

  typedef struct { logic [31:0] pix; logic last; string req; } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0, cyc = 0, sent = 0;
  bit fullrate = 0, randbp = 0, done = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: one pixel, expected result pushed at acceptance
  task automatic send(input logic [7:0] idx, input logic [31:0] dw,
                      input logic [31:0] cw, input logic bgr);
    exp_t e;
    @(negedge clk);
    in_valid = 1; in_index = idx; in_direct = dw; in_ctrl = cw; bgr_sel = bgr;
    #0.5;
    while (!in_ready) begin @(negedge clk); #0.5; end
    if (cw[31:24] == 8'h03) begin
      e.pix = bgr ? {8'h00, dw[23:16], dw[15:8], dw[7:0]}
                  : {8'h00, dw[7:0], dw[15:8], dw[23:16]};
      e.req = bgr ? "R1 R3 R4 R6 bgr" : "R1 R3 R4 R6 rgb";
    end else begin
      e.pix = pal[idx];
      e.req = "R2 R5 R11 table";
    end
    e.last = ((sent % LW) == LW - 1);
    sent++;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  // sink readiness
  always @(negedge clk) out_ready <= randbp ? (($urandom % 3) != 0) : 1'b1;

  // monitor
  logic [31:0] held_pix;
  logic        held_last, was_stalled = 0, have_prev = 0;
  int          prev_cyc = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1) begin
      if (was_stalled) begin
        check(out_valid === 1'b1 && out_pixel === held_pix && out_last === held_last,
              "R8 stalled output held", out_pixel, held_pix);
      end
      was_stalled = 0;
      if (out_valid && !out_ready) begin
        held_pix = out_pixel; held_last = out_last; was_stalled = 1;
        check(in_ready === 1'b0, "R8 input stalled", {31'd0, in_ready}, 32'd0);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected output", out_pixel, 32'hx);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_pixel === e.pix, e.req, out_pixel, e.pix);
          check(out_last === e.last, "R9 line end flag", {31'd0, out_last}, {31'd0, e.last});
          if (fullrate && have_prev)
            check(cyc == prev_cyc + 1, "R7 one pixel per clock", cyc, prev_cyc + 1);
          prev_cyc = cyc; have_prev = 1;
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; in_index = 0; in_direct = 0; in_ctrl = 0; bgr_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #0.5;
    check(out_valid === 1'b0, "R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    check(in_ready === 1'b1, "R10 reset in_ready", {31'd0, in_ready}, 32'd1);

    // full rate, mixed paths
    fullrate = 1;
    for (int i = 0; i < 14; i++)
      send(8'(i * 17), {8'hEE, 8'(i), 8'(i + 40), 8'(i + 90)},
           (i % 3 == 0) ? 32'h03FF_FFFF : 32'h0100_0000, 1'b0);
    idle();
    repeat (6) @(negedge clk);
    fullrate = 0; have_prev = 0;

    // tag sweep, packing toggled per pixel, noise in byte 0
    send(8'h10, 32'hAB11_2233, 32'h0000_0000, 1'b1);
    send(8'h20, 32'hCD44_5566, 32'h0300_0000, 1'b1);
    send(8'h30, 32'h7744_5566, 32'h0300_1234, 1'b0);
    send(8'h40, 32'h0177_8899, 32'h1300_0000, 1'b0);
    send(8'h50, 32'hFF77_8899, 32'h8300_0000, 1'b1);
    send(8'h60, 32'h12AA_BBCC, 32'h0200_0000, 1'b0);
    send(8'hFF, 32'h34AA_BBCC, 32'hFF00_0000, 1'b1);
    send(8'h00, 32'h5601_0203, 32'h03AB_CDEF, 1'b1);
    send(8'h00, 32'h9801_0203, 32'h0300_0000, 1'b0);
    idle();
    repeat (6) @(negedge clk);

    // random backpressure
    randbp = 1;
    for (int i = 0; i < 80; i++) begin
      logic [31:0] r = $urandom;
      send(8'($urandom), $urandom, (r[1:0] == 2'b00) ? {8'h03, r[31:8]} : r, r[4]);
      if (r[6:5] == 2'b00) idle();
    end
    idle();
    randbp = 0;
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 all pixels delivered", exp_q.size(), 0);
    finish_run();
  end

endmodule